// File: doc/BRIEF.md
# Multi-Lane Receiver Presence Controller

This block sequences receiver-presence probing for a four-lane serial redriver and decides which lane outputs may drive. It watches three asynchronous control levels: a master enable, a probe request and a power-save select. When enable comes up, and again on each new request while enable stays high, it starts a probe on every active lane. Each lane hands a one-cycle start pulse to an analog probe outside this block. The probe answers with a done pulse that carries a found bit. The analog probe, the equalizer and the swing settings are not part of this block.

Until some lane finds a far-end receiver, every lane keeps probing with no limit. The first find caps every lane that is still searching at a small number of further failed attempts. A lane that finds a receiver enables its output and its electrical-idle detector once no lane is still probing. Whenever its idle indicator shows the input below threshold, an enabled lane mutes its output. In power-save mode only lane 0 probes and watches idle, and lanes 1 to 3 copy lane 0's enable and mute state. None of the interfaces carries a data stream, so every pin is a plain level or pulse with no valid/ready handshake.

Top module: `lane_presence_ctrl`

## Requirements
- R1: Enable, request and power-save each pass through two synchronizing flops. A rise of synchronized enable starts a probe cycle on every active lane, and this includes enable already high when reset is released. The lane start pulses first appear in the cycle after the third rising clock edge that follows the enable change.
- R2: A rising edge of the synchronized request starts a new probe cycle while enable is high. A request while enable is low does nothing, and holding the request high does not retrigger.
- R3: The standby output is high while enable is low or any lane is probing. Output enable and idle-detector enable are low on every lane while standby is high.
- R4: Each start pulse lasts exactly one cycle. A lane issues no further start until its done pulse has returned, and it counts each returned done as one attempt.
- R5: While no lane has found a receiver, every lane retries without limit.
- R6: The cycle in which the first found result arrives arms a 2-bit counter with the value 3 on every lane still probing. A failure that arrives in that same cycle is not counted. Each later failed attempt counts down by one, and the failure that finds the counter at 1 stops the lane. A stopped lane stays disabled.
- R7: A lane that has found a receiver drives output enable and idle-detector enable high once standby is low.
- R8: Enable going low aborts any probing. Within three clock edges standby is high, all enables are low and no further start pulses appear.
- R9: Mute for a lane is high when its output enable is low or its idle indicator is 1 (1 means input below threshold). It follows the idle indicator in the same cycle.
- R10: With power-save high, lanes 1 to 3 issue no start pulses and keep idle-detector enable low. Their output enable and mute copy lane 0's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Master enable, asynchronous |
| req_i | input | 1 | Probe request, rising edge acts, asynchronous |
| psave_i | input | 1 | Power-save select, asynchronous |
| idle_i | input | 4 | Per-lane idle indicator, 1 = input below threshold |
| probe_done_i | input | 4 | Per-lane probe completion pulse |
| probe_found_i | input | 4 | Per-lane receiver-found bit, valid with done |
| probe_start_o | output | 4 | Per-lane one-cycle probe start |
| out_en_o | output | 4 | Per-lane output driver enable |
| idle_det_en_o | output | 4 | Per-lane idle-detector enable |
| squelch_o | output | 4 | Per-lane output mute |
| standby_o | output | 1 | Global low-power standby |

## Verification
Control inputs reach the logic two edges after they change, and a start pulse is visible after the third edge. The bench samples start pulses at the falling edge that follows each of those edges. The bench's probe model sees a start at a falling edge and returns done two falling edges later. The lane takes that done at the next rising edge, so all lanes run in lockstep with a three-cycle attempt period. The expected attempt counts and final enables then follow arithmetically from the earliest found attempt. Mute is combinational from the idle indicator and is checked 1 ns after the idle value is driven.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    LS_OFF   = 3'd0,
    LS_PROBE = 3'd1,
    LS_WAIT  = 3'd2,
    LS_UP    = 3'd3,
    LS_DEAD  = 3'd4
  } lane_st_t;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpc_seq.sv
module lpc_seq #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             req_s,
  input  logic [LANES-1:0] hit,
  output logic             kick,
  output logic             abort,
  output logic             arm
);
  logic en_q, req_q, found_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      en_q  <= en_s;
      req_q <= req_s;
    end
  end

  // Enable rising (power-up included) or request rising under enable.
  assign kick  = en_s & (~en_q | (req_s & ~req_q));
  assign abort = ~en_s;
  assign arm   = (|hit) & ~found_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) found_any <= 1'b0;
    else if (abort || kick) found_any <= 1'b0;
    else if (|hit) found_any <= 1'b1;
  end
endmodule

// File: rtl/lpc_lane.sv
module lpc_lane
  import lpc_pkg::*;
#(
  parameter int RETRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic off,
  input  logic kick,
  input  logic arm,
  input  logic done,
  input  logic found,
  output logic start,
  output logic hit,
  output logic busy,
  output logic up
);
  localparam int RW = (RETRIES < 2) ? 1 : $clog2(RETRIES + 1);

  lane_st_t        st;
  logic            capped;
  logic [RW-1:0]   left;

  assign start = (st == LS_PROBE);
  assign busy  = (st == LS_PROBE) || (st == LS_WAIT);
  assign up    = (st == LS_UP);
  assign hit   = (st == LS_WAIT) && done && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LS_OFF;
      capped <= 1'b0;
      left   <= '0;
    end else if (abort || off) begin
      st     <= LS_OFF;
      capped <= 1'b0;
      left   <= '0;
    end else begin
      if (kick) capped <= 1'b0;
      else if (arm && busy) begin
        capped <= 1'b1;
        left   <= RW'(RETRIES);
      end
      unique case (st)
        LS_OFF, LS_UP, LS_DEAD: if (kick) st <= LS_PROBE;
        LS_PROBE: st <= LS_WAIT;
        LS_WAIT: begin
          if (done) begin
            if (found) st <= LS_UP;
            else if (capped && !kick && !arm) begin
              if (left == RW'(1)) st <= LS_DEAD;
              else begin
                left <= left - RW'(1);
                st   <= LS_PROBE;
              end
            end else st <= LS_PROBE;
          end
        end
        default: st <= LS_OFF;
      endcase
    end
  end
endmodule

// File: rtl/lane_presence_ctrl.sv
module lane_presence_ctrl #(
  parameter int LANES       = 4,
  parameter int RETRIES     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             psave_i,
  input  logic [LANES-1:0] idle_i,
  input  logic [LANES-1:0] probe_done_i,
  input  logic [LANES-1:0] probe_found_i,
  output logic [LANES-1:0] probe_start_o,
  output logic [LANES-1:0] out_en_o,
  output logic [LANES-1:0] idle_det_en_o,
  output logic [LANES-1:0] squelch_o,
  output logic             standby_o
);
  logic [2:0] sync_q;
  logic en_s, req_s, psave_s;
  logic kick, abort, arm;
  logic [LANES-1:0] hit, busy, up, own_on, own_sq;

  lpc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({psave_i, req_i, en_i}),
    .q(sync_q)
  );
  assign en_s    = sync_q[0];
  assign req_s   = sync_q[1];
  assign psave_s = sync_q[2];

  lpc_seq #(.LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .en_s(en_s), .req_s(req_s), .hit(hit),
    .kick(kick), .abort(abort), .arm(arm)
  );

  assign standby_o = ~en_s | (|busy) | kick;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic off;
      if (i == 0) begin : g_master
        assign off = 1'b0;
      end else begin : g_slave
        assign off = psave_s;
      end

      lpc_lane #(.RETRIES(RETRIES)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .abort(abort), .off(off), .kick(kick), .arm(arm),
        .done(probe_done_i[i]), .found(probe_found_i[i]),
        .start(probe_start_o[i]), .hit(hit[i]),
        .busy(busy[i]), .up(up[i])
      );

      assign own_on[i]        = up[i] & ~standby_o;
      assign own_sq[i]        = ~own_on[i] | idle_i[i];
      assign idle_det_en_o[i] = own_on[i];

      if (i == 0) begin : g_out0
        assign out_en_o[i]  = own_on[i];
        assign squelch_o[i] = own_sq[i];
      end else begin : g_outn
        assign out_en_o[i]  = psave_s ? own_on[0] : own_on[i];
        assign squelch_o[i] = psave_s ? own_sq[0] : own_sq[i];
      end
    end
  endgenerate
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_s,
  input logic             psave_s,
  input logic             standby_o,
  input logic [LANES-1:0] probe_start_o,
  input logic [LANES-1:0] out_en_o,
  input logic [LANES-1:0] idle_det_en_o,
  input logic [LANES-1:0] squelch_o
);
  // R3: standby keeps every lane dark
  p_standby_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> (out_en_o == '0) && (idle_det_en_o == '0));

  // R8: enable low leaves no start pulse one cycle later
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (probe_start_o == '0));

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_chk
      // R4: start is a single-cycle pulse
      p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        probe_start_o[i] |=> !probe_start_o[i]);

      // R9: a disabled lane is always muted
      p_mute_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_o[i] |-> squelch_o[i]);

      if (i > 0) begin : g_slave
        // R10: slaved lanes do not probe once power-save has settled
        p_slave_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
          (psave_s && $past(psave_s)) |-> !probe_start_o[i] && !idle_det_en_o[i]);
      end
    end
  endgenerate
endmodule

bind lane_presence_ctrl lpc_checker #(.LANES(LANES)) u_lpc_checker (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .psave_s(psave_s),
  .standby_o(standby_o), .probe_start_o(probe_start_o),
  .out_en_o(out_en_o), .idle_det_en_o(idle_det_en_o), .squelch_o(squelch_o)
);

// File: tb/lane_presence_ctrl_test.sv
`timescale 1ns/1ps
module lane_presence_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, req_i = 1'b0, psave_i = 1'b0;
  logic [3:0] idle_i = '0, probe_done_i = '0, probe_found_i = '0;
  logic [3:0] probe_start_o, out_en_o, idle_det_en_o, squelch_o;
  logic standby_o;

  int checks = 0, errors = 0;
  int target [4];
  int att [4];
  int cd [4];
  bit finished = 0;

  always #4 clk = ~clk;

  lane_presence_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .req_i(req_i), .psave_i(psave_i),
    .idle_i(idle_i), .probe_done_i(probe_done_i), .probe_found_i(probe_found_i),
    .probe_start_o(probe_start_o), .out_en_o(out_en_o),
    .idle_det_en_o(idle_det_en_o), .squelch_o(squelch_o), .standby_o(standby_o)
  );

  // Probe model: done two falling edges after a start is seen.
  initial begin
    for (int i = 0; i < 4; i++) begin target[i] = 0; att[i] = 0; cd[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        probe_done_i[i]  = 1'b0;
        probe_found_i[i] = 1'b0;
        if (cd[i] > 0) begin
          cd[i]--;
          if (cd[i] == 0) begin
            probe_done_i[i]  = 1'b1;
            probe_found_i[i] = (target[i] != 0) && (att[i] == target[i]);
          end
        end
        if (probe_start_o[i]) begin
          att[i]++;
          cd[i] = 2;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 4; i++) att[i] = 0;
  endtask

  // Drop enable, drain, then raise it with the given per-lane find attempts.
  task automatic run_case(input int a0, input int a1, input int a2, input int a3);
    int f;
    en_i = 1'b0;
    repeat (8) @(negedge clk);
    #1;
    target[0] = a0; target[1] = a1; target[2] = a2; target[3] = a3;
    clear_counts();
    en_i = 1'b1;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (k > 4 && !standby_o) break;
    end
    #1;
    f = 0;
    for (int i = 0; i < 4; i++)
      if (target[i] != 0 && (f == 0 || target[i] < f)) f = target[i];
    if (f == 0) begin
      chk(standby_o == 1'b1, "R5 standby while searching", standby_o, 1);
      for (int i = 0; i < 4; i++) begin
        chk(att[i] > 6, "R5 unlimited retries", att[i], 7);
        chk(out_en_o[i] == 1'b0, "R5 no output enable", out_en_o[i], 0);
      end
    end else begin
      chk(standby_o == 1'b0, "R3 standby released", standby_o, 0);
      for (int i = 0; i < 4; i++) begin
        bit lk;
        int ea;
        lk = (target[i] != 0) && (target[i] <= f + 3);
        ea = lk ? target[i] : f + 3;
        chk(att[i] == ea, "R4/R6 attempt count", att[i], ea);
        chk(out_en_o[i] == lk, "R7/R6 output enable", out_en_o[i], int'(lk));
        chk(idle_det_en_o[i] == lk, "R7 idle detector enable", idle_det_en_o[i], int'(lk));
        chk(squelch_o[i] == !lk, "R9 mute on disabled lane", squelch_o[i], int'(!lk));
      end
    end
  endtask

  initial begin
    int vals [5];
    int snap;
    vals = '{0, 1, 2, 4, 5};
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(standby_o == 1'b1, "R3 reset standby", standby_o, 1);
    chk(probe_start_o == 4'h0, "R1 reset no start", probe_start_o, 0);
    chk(out_en_o == 4'h0, "R3 reset outputs off", out_en_o, 0);
    target[0] = 1; target[1] = 1; target[2] = 1; target[3] = 1;
    rst_n = 1'b1;
    // R1: en high at reset release -> starts after third edge
    @(negedge clk);
    chk(probe_start_o == 4'h0, "R1 edge1", probe_start_o, 0);
    @(negedge clk);
    chk(probe_start_o == 4'h0, "R1 edge2", probe_start_o, 0);
    @(negedge clk);
    chk(probe_start_o == 4'hF, "R1 edge3 start all lanes", probe_start_o, 15);
    @(negedge clk);
    chk(probe_start_o == 4'h0, "R4 single-cycle start", probe_start_o, 0);
    repeat (6) @(negedge clk);
    chk(out_en_o == 4'hF, "R7 linked at power-up", out_en_o, 15);

    // R9: mute follows idle in the same cycle
    idle_i = 4'b0100; #1;
    chk(squelch_o == 4'b0100, "R9 idle mutes lane 2", squelch_o, 4);
    idle_i = 4'b0000; #1;
    chk(squelch_o == 4'b0000, "R9 activity unmutes", squelch_o, 0);

    // R2: request edge restarts, held request does not retrigger
    @(negedge clk);
    clear_counts();
    req_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(standby_o == 1'b1, "R2 request restarts standby", standby_o, 1);
    repeat (20) @(negedge clk);
    chk(att[0] == 1 && att[3] == 1, "R2 one new attempt", att[0], 1);
    chk(out_en_o == 4'hF, "R2 relinked", out_en_o, 15);
    // R2: request with enable low is ignored
    req_i = 1'b0;
    en_i = 1'b0;
    repeat (6) @(negedge clk);
    clear_counts();
    req_i = 1'b1;
    repeat (10) @(negedge clk);
    chk(att[0] == 0, "R2 request ignored when disabled", att[0], 0);
    chk(standby_o == 1'b1, "R2 standby stays", standby_o, 1);
    req_i = 1'b0;

    // R8: abort during endless search
    run_case(0, 0, 0, 0);
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(standby_o == 1'b1 && out_en_o == 4'h0, "R8 abort standby", standby_o, 1);
    snap = att[1];
    repeat (20) @(negedge clk);
    chk(att[1] == snap, "R8 no probes after abort", att[1], snap);

    // Sweep of find attempts per lane (R4 R5 R6 R7)
    for (int c = 0; c < 625; c++)
      run_case(vals[c % 5], vals[(c / 5) % 5], vals[(c / 25) % 5], vals[(c / 125) % 5]);

    // R10: power-save slaving
    en_i = 1'b0;
    psave_i = 1'b1;
    repeat (8) @(negedge clk);
    target[0] = 2; target[1] = 1; target[2] = 1; target[3] = 1;
    clear_counts();
    en_i = 1'b1;
    repeat (30) @(negedge clk);
    #1;
    chk(att[0] == 2, "R10 lane 0 probes", att[0], 2);
    chk(att[1] + att[2] + att[3] == 0, "R10 slaves silent", att[1] + att[2] + att[3], 0);
    chk(out_en_o == 4'hF, "R10 slaves copy enable", out_en_o, 15);
    chk(idle_det_en_o == 4'b0001, "R10 slave idle detectors off", idle_det_en_o, 1);
    idle_i = 4'b0001; #1;
    chk(squelch_o == 4'hF, "R10 slaves copy mute", squelch_o, 15);
    idle_i = 4'b1110; #1;
    chk(squelch_o == 4'h0, "R10 slave idle ignored", squelch_o, 0);
    idle_i = 4'b0000;
    psave_i = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule